// File: doc/BRIEF.md
# Banked Working-Register Memory with Hardware Stack

This block is the 128-byte scratch memory of a small processor core. It gives three views of the same storage. A plain byte port reads and writes any address. A working-register port takes a register number from 0 to 7 and turns it into a byte address. The bank used for that lookup comes from two bits of a status byte, so four banks of eight registers sit at the bottom of the memory. A stack port pushes and pops bytes through the memory under an 8-bit stack pointer. The stack pointer always holds the address of the most recent push. Software can also load the pointer directly.

The status byte holds the carry, auxiliary-carry, user, bank-select and overflow flags. Its lowest bit is the parity of the accumulator. That parity is computed from an accumulator input on every cycle and is never stored. Push data enters as a valid/ready stream. Pop data leaves as a valid/ready stream, and the consumer takes the top byte by raising `pop_ready` while `pop_valid` is high. A direct load of the stack pointer blocks both stack streams in that cycle. A push blocks a pop in that cycle. The memory accepts one write per clock.

Top module: `bankreg_stack_top`

## Requirements
- R1: After reset the stack pointer reads 0x07, the stored status bits read zero (bank 0 selected), and the memory reads zero.
- R2: A register access to register n (0..7) uses byte address bank*8 + n, for both reads and writes.
- R3: The bank is status bits [4:3] (bit 4 is the high bank bit). A status write takes effect for register accesses from the next cycle.
- R4: An accepted push raises the stack pointer by one and writes the byte at the new address. `pop_data` shows the byte at the current pointer. An accepted pop lowers the pointer by one.
- R5: When `sp_wr_en` is high, the pointer takes `sp_wdata` on the next edge. In that cycle `push_ready` and `pop_valid` are low, and no stack transfer happens.
- R6: Status bit 0 always equals the XOR of the eight accumulator bits. The value written to bit 0 has no effect.
- R7: A status write stores bits [7:1] in this layout: 7 carry, 6 auxiliary carry, 5 user flag, 4 and 3 bank select, 2 overflow, 1 spare. Without a write, these bits hold.
- R8: A byte address of 128 or more ignores writes and reads as zero. This holds for the byte port and for the stack, so a push that takes the pointer to 0x80 stores nothing.
- R9: A push and a pop are never accepted in the same cycle. While `push_valid` is high, `pop_valid` is low.
- R10: Only one memory write happens per cycle. A push write beats a byte-port write, and a byte-port write beats a register write. A write that loses is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_i | input | 8 | Accumulator value, used for parity |
| psw_wr_en | input | 1 | Status write strobe |
| psw_wdata | input | 8 | Status write data |
| psw_o | output | 8 | Status byte, with parity in bit 0 |
| sp_wr_en | input | 1 | Direct stack-pointer load |
| sp_wdata | input | 8 | Stack-pointer load value |
| sp_o | output | 8 | Current stack pointer |
| mem_wr_en | input | 1 | Byte-port write strobe |
| mem_addr | input | 8 | Byte-port address |
| mem_wdata | input | 8 | Byte-port write data |
| mem_rdata | output | 8 | Byte-port read data (combinational) |
| reg_wr_en | input | 1 | Register-port write strobe |
| reg_idx | input | 3 | Register number |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| push_valid | input | 1 | Push byte offered |
| push_ready | output | 1 | Push can be accepted |
| push_data | input | 8 | Byte to push |
| pop_valid | output | 1 | Top byte can be taken |
| pop_ready | input | 1 | Consumer takes the top byte |
| pop_data | output | 8 | Byte at the stack pointer |

## Verification
The collisions that matter happen in a single cycle. A push can meet a pop, a pointer load can meet a pending push, and a stack write can meet a byte-port or register write. Each case is provoked by raising both requests on the same falling edge. The checks then cover the handshake outputs before the edge, and the pointer and the memory contents through the byte port after the edge. A status write that changes the bank while a register write is pending is also judged by where that byte lands.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;
  parameter int DW        = 8;
  parameter int DEPTH     = 128;
  parameter int NREG      = 8;
  parameter int NBANK     = 4;
  parameter int AW        = $clog2(DEPTH);
  parameter int RW        = $clog2(NREG);
  parameter int BW        = $clog2(NBANK);
  parameter int BANK_LSB  = 3;
  parameter logic [DW-1:0] SP_RESET = 8'h07;
  typedef logic [DW-1:0] byte_t;
endpackage

// File: rtl/bankreg_ram.sv
module bankreg_ram
  import bankreg_pkg::*;
#(
  parameter int NRD = 3
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  we,
  input  byte_t waddr,
  input  byte_t wdata,
  input  byte_t raddr [NRD],
  output byte_t rdata [NRD]
);
  byte_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we && (int'(waddr) < DEPTH)) begin
      mem[waddr[AW-1:0]] <= wdata;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata[g] = (int'(raddr[g]) < DEPTH) ? mem[raddr[g][AW-1:0]] : '0;
    // Reads beyond the array must return zero (R8)
    always_comb begin
      if (rst_n && int'(raddr[g]) >= DEPTH)
        p_oor_zero_r8: assert (rdata[g] == '0);
    end
  end
endmodule

// File: rtl/bankreg_sp.sv
module bankreg_sp
  import bankreg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  byte_t load_val,
  input  logic  inc,
  input  logic  dec,
  output byte_t sp
);
  always_ff @(posedge clk) begin
    if (!rst_n)    sp <= SP_RESET;
    else if (load) sp <= load_val;
    else if (inc)  sp <= sp + 1'b1;
    else if (dec)  sp <= sp - 1'b1;
  end

  p_push_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load) |=> sp == $past(sp) + 8'd1);
  p_pop_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !inc && !load) |=> sp == $past(sp) - 8'd1);
  p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> sp == $past(load_val));
endmodule

// File: rtl/bankreg_status.sv
module bankreg_status
  import bankreg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  byte_t       wdata,
  input  byte_t       acc,
  output byte_t       psw,
  output logic [BW-1:0] bank
);
  logic [DW-1:1] flags;

  always_ff @(posedge clk) begin
    if (!rst_n)     flags <= '0;
    else if (wr_en) flags <= wdata[DW-1:1];
  end

  assign psw  = {flags, ^acc};
  assign bank = flags[BANK_LSB+BW-1:BANK_LSB];

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(psw[DW-1:1]));
  p_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> psw[DW-1:1] == $past(wdata[DW-1:1]));
endmodule

// File: rtl/bankreg_stack_top.sv
module bankreg_stack_top
  import bankreg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] acc_i,
  input  logic       psw_wr_en,
  input  logic [7:0] psw_wdata,
  output logic [7:0] psw_o,
  input  logic       sp_wr_en,
  input  logic [7:0] sp_wdata,
  output logic [7:0] sp_o,
  input  logic       mem_wr_en,
  input  logic [7:0] mem_addr,
  input  logic [7:0] mem_wdata,
  output logic [7:0] mem_rdata,
  input  logic       reg_wr_en,
  input  logic [2:0] reg_idx,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       push_valid,
  output logic       push_ready,
  input  logic [7:0] push_data,
  output logic       pop_valid,
  input  logic       pop_ready,
  output logic [7:0] pop_data
);
  localparam int NRD = 3;

  logic [BW-1:0] bank;
  byte_t sp, sp_next_up, reg_addr;
  logic  push_fire, pop_fire;
  logic  we;
  byte_t waddr, wdata;
  byte_t raddr [NRD];
  byte_t rdata [NRD];

  bankreg_status u_status (
    .clk(clk), .rst_n(rst_n), .wr_en(psw_wr_en), .wdata(psw_wdata),
    .acc(acc_i), .psw(psw_o), .bank(bank)
  );

  assign push_ready = !sp_wr_en;
  assign pop_valid  = !sp_wr_en && !push_valid;
  assign push_fire  = push_valid && push_ready;
  assign pop_fire   = pop_valid && pop_ready;

  bankreg_sp u_sp (
    .clk(clk), .rst_n(rst_n), .load(sp_wr_en), .load_val(sp_wdata),
    .inc(push_fire), .dec(pop_fire), .sp(sp)
  );

  assign sp_o       = sp;
  assign sp_next_up = sp + 1'b1;
  assign reg_addr   = byte_t'({bank, reg_idx[RW-1:0]});

  // One write port: stack beats byte port beats register port
  always_comb begin
    we    = 1'b0;
    waddr = '0;
    wdata = '0;
    if (push_fire) begin
      we = 1'b1; waddr = sp_next_up; wdata = push_data;
    end else if (mem_wr_en) begin
      we = 1'b1; waddr = mem_addr;   wdata = mem_wdata;
    end else if (reg_wr_en) begin
      we = 1'b1; waddr = reg_addr;   wdata = reg_wdata;
    end
  end

  assign raddr[0] = mem_addr;
  assign raddr[1] = reg_addr;
  assign raddr[2] = sp;
  assign mem_rdata = rdata[0];
  assign reg_rdata = rdata[1];
  assign pop_data  = rdata[2];

  bankreg_ram #(.NRD(NRD)) u_ram (
    .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(raddr), .rdata(rdata)
  );

  p_no_push_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_fire && pop_fire));
  p_pushed_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (push_fire && int'(sp_next_up) < DEPTH) |=> pop_data == $past(push_data));
  p_load_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sp_wr_en |-> (!push_ready && !pop_valid));
endmodule

// File: tb/sim_bankreg_stack_top.sv
`timescale 1ns/1ps
module sim_bankreg_stack_top;
  logic clk = 0, rst_n = 0;
  logic [7:0] acc_i = 0, psw_wdata = 0, sp_wdata = 0, mem_addr = 0, mem_wdata = 0;
  logic [7:0] reg_wdata = 0, push_data = 0;
  logic [2:0] reg_idx = 0;
  logic psw_wr_en = 0, sp_wr_en = 0, mem_wr_en = 0, reg_wr_en = 0;
  logic push_valid = 0, pop_ready = 0;
  logic [7:0] psw_o, sp_o, mem_rdata, reg_rdata, pop_data;
  logic push_ready, pop_valid;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  bankreg_stack_top u0 (.*);

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick; @(posedge clk); @(negedge clk); endtask

  task automatic idle;
    psw_wr_en = 0; sp_wr_en = 0; mem_wr_en = 0; reg_wr_en = 0;
    push_valid = 0; pop_ready = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    mem_addr = a; #1 d = mem_rdata;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 sp", sp_o, 8'h07);
    chk("R1 psw", psw_o, 8'h00);
    rd(8'h05, d); chk("R1 mem", d, 8'h00);
  endtask

  task automatic t_regs;
    logic [7:0] d;
    reg_idx = 3; reg_wdata = 8'h3C; reg_wr_en = 1; tick; idle;
    rd(8'd3, d); chk("R2 bank0 r3", d, 8'h3C);
    psw_wdata = 8'h18; psw_wr_en = 1; reg_idx = 5; reg_wdata = 8'hAA; reg_wr_en = 1;
    tick; idle;   // write used old bank 0
    rd(8'd5, d); chk("R3 old bank", d, 8'hAA);
    reg_wdata = 8'h5D; reg_wr_en = 1; tick; idle;
    rd(8'd29, d); chk("R2 R3 bank3 r5", d, 8'h5D);
    #1 chk("R2 reg read", reg_rdata, 8'h5D);
    psw_wdata = 8'h08; psw_wr_en = 1; tick; idle;
    reg_idx = 7; reg_wdata = 8'h71; reg_wr_en = 1; tick; idle;
    rd(8'd15, d); chk("R2 bank1 r7", d, 8'h71);
    psw_wdata = 8'h00; psw_wr_en = 1; tick; idle;
  endtask

  task automatic t_status;
    acc_i = 8'h07; #1 chk("R6 parity odd", psw_o, 8'h01);
    acc_i = 8'h00; psw_wdata = 8'hE7; psw_wr_en = 1; tick; idle;
    #1 chk("R7 R6 layout", psw_o, 8'hE6);
    acc_i = 8'h01; #1 chk("R6 tracks acc", psw_o, 8'hE7);
    tick; chk("R7 hold", psw_o, 8'hE7);
    acc_i = 0; psw_wdata = 0; psw_wr_en = 1; tick; idle;
  endtask

  task automatic t_stack;
    logic [7:0] d;
    push_data = 8'hA1; push_valid = 1; #1 chk("R9 pop blocked", {7'd0, pop_valid}, 8'd0);
    tick; push_data = 8'hB2; tick; idle;
    chk("R4 sp after push", sp_o, 8'h09);
    rd(8'd8, d); chk("R4 first byte", d, 8'hA1);
    #1 chk("R4 top", pop_data, 8'hB2);
    pop_ready = 1; tick; idle;
    chk("R4 sp after pop", sp_o, 8'h08);
    #1 chk("R4 next top", pop_data, 8'hA1);
  endtask

  task automatic t_load;
    logic [7:0] d;
    sp_wdata = 8'h40; sp_wr_en = 1; push_valid = 1; push_data = 8'hEE;
    #1 chk("R5 push_ready low", {7'd0, push_ready}, 8'd0);
    tick; idle;
    chk("R5 sp loaded", sp_o, 8'h40);
    rd(8'h41, d); chk("R5 no push", d, 8'h00);
    sp_wdata = 8'h7F; sp_wr_en = 1; tick; idle;
    push_data = 8'h55; push_valid = 1; tick; idle;
    chk("R8 sp 0x80", sp_o, 8'h80);
    #1 chk("R8 pop reads zero", pop_data, 8'h00);
    mem_addr = 8'h90; mem_wdata = 8'h12; mem_wr_en = 1; tick; idle;
    rd(8'h90, d); chk("R8 high addr", d, 8'h00);
    rd(8'h10, d); chk("R8 no alias", d, 8'h00);
  endtask

  task automatic t_priority;
    logic [7:0] d;
    sp_wdata = 8'h20; sp_wr_en = 1; tick; idle;
    push_data = 8'hC3; push_valid = 1; mem_addr = 8'h21; mem_wdata = 8'h99; mem_wr_en = 1;
    tick; idle;
    rd(8'h21, d); chk("R10 push wins", d, 8'hC3);
    mem_addr = 8'h30; mem_wdata = 8'h44; mem_wr_en = 1;
    reg_idx = 2; reg_wdata = 8'h66; reg_wr_en = 1; tick; idle;
    rd(8'h30, d); chk("R10 mem wins", d, 8'h44);
    rd(8'h02, d); chk("R10 reg dropped", d, 8'h00);
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1; @(negedge clk);
    t_reset;
    t_regs;
    t_status;
    t_stack;
    t_load;
    t_priority;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule